// File: doc/BRIEF.md
# Clustered Vector Register Renamer and Instruction Steerer

This block is the issue-side control of a vector unit whose register file is split into clusters. Each cluster owns a fixed number of physical vector registers and a short instruction queue, and executes one kind of work: arithmetic, memory access, or parking values for later use. Software names architectural vector registers only. The block keeps a map from each architectural register to the cluster and slot that hold its latest value. For each vector instruction it chooses a cluster able to run it, reports which source operands must cross the intercluster network, gives the result a fresh physical register in that cluster, and appends the renamed instruction to that cluster's queue.

Instructions arrive through a valid/ready input, one per cycle at most. An accepted instruction is held in a single holding stage and leaves it in the cycle after acceptance, unless its cluster has no room. The issue control has two states. `ST_EMPTY` means no instruction is held. `ST_HELD` means one instruction waits for issue. The transitions are: capture (`ST_EMPTY` to `ST_HELD` when input is valid); issue-and-refill (stay in `ST_HELD` when the held instruction issues and a new one is accepted in the same cycle); issue-and-drain (`ST_HELD` to `ST_EMPTY` when it issues with no new input); stall (stay in `ST_HELD` when it cannot issue). Each cluster's datapath pops its queue. When an instruction that overwrote a register completes, the datapath returns the physical register that held the previous value, and the block recycles it.

Top module: `vec_cluster_steer`

## Requirements
- R1: After reset no architectural register is mapped, every physical slot is free, every queue is empty, `in_ready` is high, and `iss_fire` and both `xfer_valid` bits are low.
- R2: An instruction issues only to a cluster whose kind matches its class. Class encoding is 0 arithmetic, 1 memory, 2 park. With default parameters clusters 0 and 1 are arithmetic, cluster 2 is memory and cluster 3 is park.
- R3: Among eligible clusters, the one holding the most mapped source operands is chosen. A register named in both source positions counts twice.
- R4: When eligible clusters hold equally many sources, the one with the fewest queued instructions wins, and then the lowest cluster index.
- R5: In the issue cycle, each mapped source held in a cluster other than the chosen one raises one transfer request. Channel 0 carries source A and channel 1 carries source B. Each request gives the source physical register and the chosen cluster as target. When both sources are the same remote register, only channel 0 is raised.
- R6: A source that has never been written is unmapped. It raises no transfer and adds nothing to any cluster's score.
- R7: The destination receives the lowest-numbered free slot of the chosen cluster. Its physical number is cluster × 8 + slot. Later instructions that read that architectural register see this new physical register.
- R8: A queue entry is 31 bits wide, packed as follows: bits 30:23 tag, 22:18 destination physical register, 17 previous-mapping valid, 16:12 previous physical register, 11 source A valid, 10:6 source A physical register, 5 source B valid, 4:0 source B physical register. Entries leave each queue in issue order.
- R9: When the chosen cluster's queue holds four entries, the held instruction stalls. `in_ready` is low, no transfer is raised, and the instruction issues in the cycle after a pop frees space.
- R10: When the chosen cluster has no free slot, the held instruction stalls in the same way.
- R11: A completion naming a physical register frees its slot. A stalled instruction may then take that slot in the next cycle.
- R12: Back-to-back instructions issue on consecutive cycles. Each one issues in the cycle after its acceptance, and `in_ready` stays high while issue proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Instruction accepted this cycle when high together with in_valid |
| in_cls | input | 2 | Instruction class: 0 arithmetic, 1 memory, 2 park |
| in_src_a | input | 5 | Architectural source A |
| in_src_b | input | 5 | Architectural source B |
| in_dst | input | 5 | Architectural destination |
| in_tag | input | 8 | Opaque instruction tag carried into the queue |
| iss_fire | output | 1 | Held instruction issues this cycle |
| iss_cluster | output | 2 | Chosen cluster |
| iss_dst_preg | output | 5 | Physical register given to the destination |
| xfer_valid | output | 2 | Transfer request per channel (bit 0 source A, bit 1 source B) |
| xfer_src_preg | output | 10 | Source physical register per channel, channel 0 in bits 4:0 |
| xfer_dst_cluster | output | 4 | Target cluster per channel, channel 0 in bits 1:0 |
| q_valid | output | 4 | Queue head valid per cluster |
| q_data | output | 124 | Queue head entry per cluster, cluster c in bits 31c+30:31c |
| q_pop | input | 4 | Pop the head of each cluster queue (ignored when empty) |
| cmp_valid | input | 1 | Completion returns a previous physical register |
| cmp_preg | input | 5 | Physical register to free |

## Verification
The embedded assertions check on every cycle that the issue cluster matches the instruction class, that every raised transfer targets the chosen cluster from a different one, that queues never overflow, that allocation and release never collide on a slot, and that a stalled instruction holds still. Cluster choice by score and occupancy, the exact slot numbers handed out, the previous mapping carried into queue entries, and recovery from queue-full and slot-exhaustion stalls can only be shown by the bench's instruction sequences, where the history of earlier issues sets the expected values.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    // Kind of work a cluster performs; also the class field of an instruction.
    typedef enum logic [1:0] {
        KIND_ARITH = 2'd0,
        KIND_MEM   = 2'd1,
        KIND_PARK  = 2'd2
    } unit_kind_e;

    // Issue control states.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } issue_st_e;

endpackage

// File: rtl/vcs_map_table.sv
module vcs_map_table #(
    parameter int NUM_ARCH = 32,
    parameter int PW       = 5,
    localparam int AW      = $clog2(NUM_ARCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_d,
    output logic          a_valid,
    output logic [PW-1:0] a_preg,
    output logic          b_valid,
    output logic [PW-1:0] b_preg,
    output logic          d_valid,
    output logic [PW-1:0] d_preg,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_preg
);

    logic          mapped [NUM_ARCH];
    logic [PW-1:0] where   [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                mapped[i] <= 1'b0;
                where[i]  <= '0;
            end
        end else if (wr_en) begin
            mapped[wr_idx] <= 1'b1;
            where[wr_idx]  <= wr_preg;
        end
    end

    always_comb begin
        a_valid = mapped[rd_a];
        a_preg  = where[rd_a];
        b_valid = mapped[rd_b];
        b_preg  = where[rd_b];
        d_valid = mapped[rd_d];
        d_preg  = where[rd_d];
    end

    // R7: a written mapping is visible on the next cycle
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mapped[$past(wr_idx)] && where[$past(wr_idx)] == $past(wr_preg)));

endmodule

// File: rtl/vcs_slot_pool.sv
module vcs_slot_pool #(
    parameter int SLOTS = 8,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [SW-1:0] alloc_slot,
    output logic          has_free,
    input  logic          rel_en,
    input  logic [SW-1:0] rel_slot
);

    logic [SLOTS-1:0] busy;

    always_comb begin
        alloc_slot = '0;
        has_free   = ~&busy;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_slot = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            if (alloc_en) busy[alloc_slot] <= 1'b1;
            if (rel_en)   busy[rel_slot]   <= 1'b0;
        end
    end

    // R10: allocation only happens while a slot is free
    a_r10_alloc_has_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> has_free);

    // R11: only an occupied slot may be released
    a_r11_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> busy[rel_slot]);

    // R7: allocation and release never name the same slot together
    a_r7_alloc_release_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && rel_en) |-> (alloc_slot != rel_slot));

endmodule

// File: rtl/vcs_cluster_queue.sv
module vcs_cluster_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 31,
    localparam int OW   = $clog2(DEPTH + 1),
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          head_valid,
    output logic [W-1:0]  head_data,
    output logic [OW-1:0] count
);

    logic [W-1:0]    store [DEPTH];
    logic [PTRW-1:0] rd_ptr, wr_ptr;
    logic            pop_ok;

    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok     = pop && (count != '0);
    assign head_valid = (count != '0);
    assign head_data  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_data;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            count <= count + OW'(push) - OW'(pop_ok);
        end
    end

    // R9: no push into a full queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < OW'(DEPTH)));

    // R9: occupancy stays within the queue depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= OW'(DEPTH));

endmodule

// File: rtl/vcs_pick.sv
module vcs_pick #(
    parameter int NCL = 4,
    parameter int OW  = 3,
    localparam int CW = $clog2(NCL)
) (
    input  logic [NCL-1:0]    elig,
    input  logic [2*NCL-1:0]  score,
    input  logic [NCL*OW-1:0] occ,
    output logic [CW-1:0]     sel,
    output logic              found
);

    logic [1:0]    best_s;
    logic [OW-1:0] best_o;

    always_comb begin
        sel    = '0;
        found  = 1'b0;
        best_s = '0;
        best_o = '0;
        for (int c = 0; c < NCL; c++) begin
            if (elig[c]) begin
                if (!found || (score[2*c +: 2] > best_s) ||
                    ((score[2*c +: 2] == best_s) && (occ[OW*c +: OW] < best_o))) begin
                    found  = 1'b1;
                    sel    = CW'(c);
                    best_s = score[2*c +: 2];
                    best_o = occ[OW*c +: OW];
                end
            end
        end
    end

endmodule

// File: rtl/vec_cluster_steer.sv
module vec_cluster_steer
    import vcs_pkg::*;
#(
    parameter int NUM_ARCH     = 32,
    parameter int NUM_CLUSTERS = 4,
    parameter int SLOTS        = 8,
    parameter int QUEUE_DEPTH  = 4,
    parameter int TAG_W        = 8,
    parameter logic [2*NUM_CLUSTERS-1:0] CLUSTER_KIND = 8'b10_01_00_00,
    localparam int CW = $clog2(NUM_CLUSTERS),
    localparam int SW = $clog2(SLOTS),
    localparam int PW = CW + SW,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int OW = $clog2(QUEUE_DEPTH + 1),
    localparam int QW = TAG_W + PW + 3 * (PW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_cls,
    input  logic [AW-1:0]            in_src_a,
    input  logic [AW-1:0]            in_src_b,
    input  logic [AW-1:0]            in_dst,
    input  logic [TAG_W-1:0]         in_tag,
    output logic                     iss_fire,
    output logic [CW-1:0]            iss_cluster,
    output logic [PW-1:0]            iss_dst_preg,
    output logic [1:0]               xfer_valid,
    output logic [2*PW-1:0]          xfer_src_preg,
    output logic [2*CW-1:0]          xfer_dst_cluster,
    output logic [NUM_CLUSTERS-1:0]  q_valid,
    output logic [NUM_CLUSTERS*QW-1:0] q_data,
    input  logic [NUM_CLUSTERS-1:0]  q_pop,
    input  logic                     cmp_valid,
    input  logic [PW-1:0]            cmp_preg
);

    // ---------------- holding stage and issue state ----------------
    issue_st_e         st, st_nxt;
    logic [1:0]        h_cls;
    logic [AW-1:0]     h_a, h_b, h_dst;
    logic [TAG_W-1:0]  h_tag;
    logic              capture;
    logic              fire;

    // ---------------- map table ----------------
    logic          a_v, b_v, d_v;
    logic [PW-1:0] a_p, b_p, d_p;
    logic [PW-1:0] new_preg;

    vcs_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a    (h_a),
        .rd_b    (h_b),
        .rd_d    (h_dst),
        .a_valid (a_v),
        .a_preg  (a_p),
        .b_valid (b_v),
        .b_preg  (b_p),
        .d_valid (d_v),
        .d_preg  (d_p),
        .wr_en   (fire),
        .wr_idx  (h_dst),
        .wr_preg (new_preg)
    );

    // ---------------- per-cluster scoring ----------------
    logic [NUM_CLUSTERS-1:0]    elig;
    logic [2*NUM_CLUSTERS-1:0]  score;
    logic [NUM_CLUSTERS*OW-1:0] occ_flat;
    logic [CW-1:0]              sel;
    logic                       sel_found;

    always_comb begin
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            elig[c] = (CLUSTER_KIND[2*c +: 2] == h_cls);
            score[2*c +: 2] = 2'(a_v && (a_p[PW-1:SW] == CW'(c)))
                            + 2'(b_v && (b_p[PW-1:SW] == CW'(c)));
        end
    end

    vcs_pick #(.NCL(NUM_CLUSTERS), .OW(OW)) u_pick (
        .elig  (elig),
        .score (score),
        .occ   (occ_flat),
        .sel   (sel),
        .found (sel_found)
    );

    // ---------------- slot pools and queues ----------------
    logic [SW-1:0] pool_slot [NUM_CLUSTERS];
    logic          pool_free [NUM_CLUSTERS];
    logic [OW-1:0] q_cnt     [NUM_CLUSTERS];
    logic [QW-1:0] entry;

    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cluster
        logic here_issue;
        logic here_release;

        assign here_issue   = fire && (sel == CW'(c));
        assign here_release = cmp_valid && (cmp_preg[PW-1:SW] == CW'(c));

        vcs_slot_pool #(.SLOTS(SLOTS)) u_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (here_issue),
            .alloc_slot (pool_slot[c]),
            .has_free   (pool_free[c]),
            .rel_en     (here_release),
            .rel_slot   (cmp_preg[SW-1:0])
        );

        vcs_cluster_queue #(.DEPTH(QUEUE_DEPTH), .W(QW)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (here_issue),
            .push_data  (entry),
            .pop        (q_pop[c]),
            .head_valid (q_valid[c]),
            .head_data  (q_data[QW*c +: QW]),
            .count      (q_cnt[c])
        );

        assign occ_flat[OW*c +: OW] = q_cnt[c];
    end

    // ---------------- issue decision ----------------
    logic sel_full, sel_free;
    logic remote_a, remote_b;

    always_comb begin
        sel_full = (q_cnt[sel] == OW'(QUEUE_DEPTH));
        sel_free = pool_free[sel];
        new_preg = {sel, pool_slot[sel]};
        fire     = (st == ST_HELD) && sel_found && !sel_full && sel_free;
        remote_a = a_v && (a_p[PW-1:SW] != sel);
        remote_b = b_v && (b_p[PW-1:SW] != sel) && !(remote_a && (a_p == b_p));
        entry    = {h_tag, new_preg, d_v, d_p, a_v, a_p, b_v, b_p};
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_EMPTY;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_EMPTY: if (in_valid) st_nxt = ST_HELD;               // capture
            ST_HELD: begin
                if (fire && !in_valid) st_nxt = ST_EMPTY;          // issue-and-drain
                else                   st_nxt = ST_HELD;           // issue-and-refill or stall
            end
            default:  st_nxt = ST_EMPTY;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready         = (st == ST_EMPTY) || fire;
        capture          = in_valid && in_ready;
        iss_fire         = fire;
        iss_cluster      = sel;
        iss_dst_preg     = new_preg;
        xfer_valid       = {remote_b && fire, remote_a && fire};
        xfer_src_preg    = {b_p, a_p};
        xfer_dst_cluster = {sel, sel};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cls <= '0;
            h_a   <= '0;
            h_b   <= '0;
            h_dst <= '0;
            h_tag <= '0;
        end else if (capture) begin
            h_cls <= in_cls;
            h_a   <= in_src_a;
            h_b   <= in_src_b;
            h_dst <= in_dst;
            h_tag <= in_tag;
        end
    end

    // R2: the issue cluster's kind matches the held class
    a_r2_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (CLUSTER_KIND[2*iss_cluster +: 2] == h_cls));

    // R5: channel 0 moves a register from another cluster into the chosen one
    a_r5_xfer0_remote: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid[0] |-> (iss_fire && xfer_dst_cluster[CW-1:0] == iss_cluster
                           && xfer_src_preg[PW-1:SW] != iss_cluster));

    // R5: channel 1 likewise
    a_r5_xfer1_remote: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid[1] |-> (iss_fire && xfer_dst_cluster[2*CW-1:CW] == iss_cluster
                           && xfer_src_preg[2*PW-1:PW+SW] != iss_cluster));

    // R9: a stalled instruction stays held unchanged
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD && !fire) |=> (st == ST_HELD && $stable(h_tag) && $stable(h_dst)));

endmodule

// File: tb/test_vec_cluster_steer.sv
module test_vec_cluster_steer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_cls = '0;
    logic [4:0]   in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic [7:0]   in_tag = '0;
    logic         iss_fire;
    logic [1:0]   iss_cluster;
    logic [4:0]   iss_dst_preg;
    logic [1:0]   xfer_valid;
    logic [9:0]   xfer_src_preg;
    logic [3:0]   xfer_dst_cluster;
    logic [3:0]   q_valid;
    logic [123:0] q_data;
    logic [3:0]   q_pop = '0;
    logic         cmp_valid = 1'b0;
    logic [4:0]   cmp_preg = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vec_cluster_steer i_vec_cluster_steer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_tag(in_tag),
        .iss_fire(iss_fire), .iss_cluster(iss_cluster), .iss_dst_preg(iss_dst_preg),
        .xfer_valid(xfer_valid), .xfer_src_preg(xfer_src_preg),
        .xfer_dst_cluster(xfer_dst_cluster),
        .q_valid(q_valid), .q_data(q_data), .q_pop(q_pop),
        .cmp_valid(cmp_valid), .cmp_preg(cmp_preg)
    );

    // {cls, srcA, srcB, dst, exp cluster, exp dst preg, exp transfer count, exp first transfer src}
    localparam logic [30:0] VEC [9] = '{
        {2'd1, 5'd0, 5'd0, 5'd1, 2'd2, 5'd16, 2'd0, 5'd0},
        {2'd1, 5'd0, 5'd0, 5'd2, 2'd2, 5'd17, 2'd0, 5'd0},
        {2'd0, 5'd1, 5'd2, 5'd3, 2'd0, 5'd0,  2'd2, 5'd16},
        {2'd0, 5'd3, 5'd3, 5'd4, 2'd0, 5'd1,  2'd0, 5'd0},
        {2'd0, 5'd1, 5'd5, 5'd6, 2'd1, 5'd8,  2'd1, 5'd16},
        {2'd0, 5'd4, 5'd6, 5'd7, 2'd1, 5'd9,  2'd1, 5'd1},
        {2'd2, 5'd7, 5'd7, 5'd8, 2'd3, 5'd24, 2'd1, 5'd9},
        {2'd0, 5'd8, 5'd3, 5'd3, 2'd0, 5'd2,  2'd1, 5'd24},
        {2'd1, 5'd3, 5'd0, 5'd9, 2'd2, 5'd18, 2'd1, 5'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nx();
        return int'(xfer_valid[0]) + int'(xfer_valid[1]);
    endfunction

    function automatic int first_src();
        if (xfer_valid[0]) return int'(xfer_src_preg[4:0]);
        if (xfer_valid[1]) return int'(xfer_src_preg[9:5]);
        return 0;
    endfunction

    function automatic logic [30:0] head(input int c);
        return q_data[31*c +: 31];
    endfunction

    // Drive at a falling edge, accept at the rising edge, sample at the next falling edge.
    task automatic present(input logic [1:0] cls, input logic [4:0] a, input logic [4:0] b,
                           input logic [4:0] d, input logic [7:0] tag);
        @(negedge clk);
        in_valid = 1'b1; in_cls = cls; in_src_a = a; in_src_b = b; in_dst = d; in_tag = tag;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 iss_fire", int'(iss_fire), 0);
        chk("R1 q_valid", int'(q_valid), 0);
        chk("R1 xfer_valid", int'(xfer_valid), 0);

        // Table walk: R2 R3 R4 (cluster), R7 (dst), R5 R6 (transfers)
        for (int i = 0; i < 9; i++) begin
            logic [30:0] v;
            v = VEC[i];
            present(v[30:29], v[28:24], v[23:19], v[18:14], 8'(i));
            chk($sformatf("R12 vec %0d fire", i), int'(iss_fire), 1);
            chk($sformatf("R2 R3 R4 vec %0d cluster", i), int'(iss_cluster), int'(v[13:12]));
            chk($sformatf("R7 vec %0d dst", i), int'(iss_dst_preg), int'(v[11:7]));
            chk($sformatf("R5 R6 vec %0d xfer count", i), nx(), int'(v[6:5]));
            chk($sformatf("R5 vec %0d xfer src", i), first_src(), int'(v[4:0]));
            if (nx() != 0)
                chk($sformatf("R5 vec %0d xfer target", i), int'(xfer_dst_cluster[1:0]),
                    int'(v[13:12]));
        end

        // R8: queue contents of cluster 0
        @(negedge clk);
        chk("R8 head valid", int'(q_valid[0]), 1);
        chk("R8 head tag", int'(head(0)[30:23]), 2);
        chk("R8 head dst", int'(head(0)[22:18]), 0);
        chk("R8 head srcA", int'({head(0)[11], head(0)[10:6]}), 32 + 16);
        chk("R8 head srcB", int'({head(0)[5], head(0)[4:0]}), 32 + 17);
        q_pop[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        q_pop[0] = 1'b0;
        chk("R8 order tag", int'(head(0)[30:23]), 7);
        chk("R8 dst", int'(head(0)[22:18]), 2);
        chk("R8 prev valid", int'(head(0)[17]), 1);
        chk("R8 prev preg", int'(head(0)[16:12]), 0);
        chk("R8 srcA", int'(head(0)[10:6]), 24);

        // R9: queue-full stall on the memory cluster
        present(2'd1, 5'd0, 5'd0, 5'd10, 8'd20);
        chk("R9 fourth entry fires", int'(iss_fire), 1);
        chk("R9 fourth entry dst", int'(iss_dst_preg), 19);
        present(2'd1, 5'd0, 5'd0, 5'd11, 8'd21);
        chk("R9 stall fire", int'(iss_fire), 0);
        chk("R9 stall ready", int'(in_ready), 0);
        chk("R9 stall xfer", int'(xfer_valid), 0);
        @(negedge clk); @(negedge clk);
        chk("R9 still stalled", int'(iss_fire), 0);
        q_pop[2] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        q_pop[2] = 1'b0;
        chk("R9 fires after pop", int'(iss_fire), 1);
        chk("R9 dst after pop", int'(iss_dst_preg), 20);

        // R10 / R11: exhaust the park cluster's slots
        q_pop[3] = 1'b1;
        for (int k = 0; k < 7; k++) begin
            present(2'd2, 5'd0, 5'd0, 5'(12 + k), 8'(30 + k));
            chk("R7 park fire", int'(iss_fire), 1);
            chk("R7 park dst", int'(iss_dst_preg), 25 + k);
        end
        present(2'd2, 5'd0, 5'd0, 5'd19, 8'd40);
        chk("R10 no slot stall", int'(iss_fire), 0);
        chk("R10 no slot ready", int'(in_ready), 0);
        @(negedge clk);
        chk("R10 still stalled", int'(iss_fire), 0);
        cmp_valid = 1'b1;
        cmp_preg  = 5'd26;
        @(posedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk("R11 fire after release", int'(iss_fire), 1);
        chk("R11 reused slot", int'(iss_dst_preg), 26);
        @(negedge clk);

        // R12 / R4: back-to-back arithmetic instructions
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'd0; in_src_a = 5'd0; in_src_b = 5'd0;
        in_dst = 5'd20; in_tag = 8'd50;
        @(posedge clk);
        @(negedge clk);
        chk("R12 first fire", int'(iss_fire), 1);
        chk("R4 first cluster", int'(iss_cluster), 0);
        chk("R7 first dst", int'(iss_dst_preg), 3);
        chk("R12 ready while issuing", int'(in_ready), 1);
        in_dst = 5'd21; in_tag = 8'd51;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 second fire", int'(iss_fire), 1);
        chk("R4 equal occupancy lowest index", int'(iss_cluster), 0);
        chk("R7 second dst", int'(iss_dst_preg), 4);
        @(negedge clk);
        chk("R12 drained", int'(iss_fire), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule